// File: doc/BRIEF.md
# In-Order-Completion Issue Scheduler

This block is the issue stage of a single-issue pipeline that feeds six execution unit classes: integer ALU, pipelined integer multiply, pipelined FP add/subtract/compare/convert, pipelined FP multiply, iterative FP divide, and load/store. The latency of every unit is fixed and known in advance. The scheduler uses those latencies to delay each instruction just long enough that its result reaches register writeback strictly after every instruction issued before it. Long and short operations can therefore overlap without a reorder buffer, and the writeback stage never has to stall.

Each cycle the decoder presents one instruction: a unit code, a destination register with a write enable, and two source registers. The scheduler either raises exactly one issue strobe or raises `stall`. It holds three kinds of state. A writeback reservation line, as long as the longest latency, records when every in-flight instruction completes. A one-bit-per-register pending table tracks operands whose results are not yet written back. A memory-wait flag freezes the whole block after a load/store issues, until the bus acknowledges. The writeback ports show which in-flight instruction completes in the current cycle.

Unit codes are 0 ALU, 1 integer multiply, 2 FP add-class, 3 FP multiply, 4 FP divide, and 5 load/store. Bit k of `issue_stb` belongs to code k. Default latencies are 1, 3, 4, 6, 12 and 2 cycles.

Top module: `inorder_issue_sched`

## Requirements
- R1: At most one bit of `issue_stb` is high in a cycle. Bit k (k = unit code 0..5) rises only in a cycle where `in_valid` is high and `stall` is low, and `stall` is high only while `in_valid` is high and nothing issues.
- R2: An instruction issued in cycle t raises `wb_valid` in cycle t+L, where L is its unit's latency counted in non-frozen cycles. In that cycle `wb_wen` equals its destination write enable and `wb_rd` equals its destination register.
- R3: An instruction of latency L issues only if every earlier in-flight instruction completes before its own completion cycle. Writebacks therefore occur in issue order, at most one per cycle.
- R4: With the default latencies, an FP multiply followed by an independent integer multiply has the integer multiply issue exactly 4 cycles after the FP multiply.
- R5: The ALU, integer multiply, FP add-class and FP multiply units accept independent instructions of the same unit in consecutive cycles.
- R6: An FP divide does not issue while an FP multiply or another FP divide is in flight. An FP multiply does not issue while an FP divide is in flight. An instruction is in flight from its issue cycle through its writeback cycle.
- R7: After a load/store (code 5) issues, every following cycle in which `mem_ack` is low is frozen: nothing issues, `wb_valid` stays low, and no in-flight work advances. The first cycle with `mem_ack` high ends the wait.
- R8: An instruction whose `in_rs1` or `in_rs2` names a register with a pending write, or whose enabled destination names one, stalls. The pending write clears at the end of its writeback cycle.
- R9: Unit codes 6 and 7 never issue. With `in_valid` high they hold `stall` high.
- R10: After reset no work is in flight and no register is pending: `wb_valid` and `stall` are low, and a valid ALU instruction issues in the first cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present |
| in_unit | input | 3 | Unit code (0..5 defined) |
| in_rd | input | log2(NREG) | Destination register |
| in_rd_en | input | 1 | Destination is written |
| in_rs1 | input | log2(NREG) | First source register |
| in_rs2 | input | log2(NREG) | Second source register |
| mem_ack | input | 1 | Bus acknowledge ending a memory wait |
| issue_stb | output | 6 | One strobe per unit code |
| stall | output | 1 | Presented instruction held this cycle |
| wb_valid | output | 1 | An in-flight instruction completes this cycle |
| wb_wen | output | 1 | The completing instruction writes a register |
| wb_rd | output | log2(NREG) | Register written by the completing instruction |

## Verification
A wrong bit in the reservation line shows at the ports within one maximum latency. Either `wb_valid` fires in the wrong cycle, or an issue that should have been delayed appears early, and the writeback that follows it comes out of issue order. A stuck pending bit shows as a permanent `stall` the first time that register is read again. A memory-wait flag that is lost or stuck shows at once, as issue or writeback during an acknowledge-low cycle, or as a freeze that never ends. The bench checks every cycle against an independent model of outstanding completions, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/inorder_issue_sched.sv
module inorder_issue_sched #(
  parameter int NREG     = 32,
  parameter int LAT_ALU  = 1,
  parameter int LAT_IMUL = 3,
  parameter int LAT_FADD = 4,
  parameter int LAT_FMUL = 6,
  parameter int LAT_FDIV = 12,
  parameter int LAT_LSU  = 2,
  localparam int RW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_unit,
  input  logic [RW-1:0] in_rd,
  input  logic          in_rd_en,
  input  logic [RW-1:0] in_rs1,
  input  logic [RW-1:0] in_rs2,
  input  logic          mem_ack,
  output logic [5:0]    issue_stb,
  output logic          stall,
  output logic          wb_valid,
  output logic          wb_wen,
  output logic [RW-1:0] wb_rd
);

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXL = imax(imax(imax(LAT_ALU, LAT_IMUL), imax(LAT_FADD, LAT_FMUL)),
                             imax(LAT_FDIV, LAT_LSU));
  localparam int LW = $clog2(MAXL + 1);
  localparam logic [2:0] U_ALU = 3'd0, U_IMUL = 3'd1, U_FADD = 3'd2,
                         U_FMUL = 3'd3, U_FDIV = 3'd4, U_LSU = 3'd5;

  logic [MAXL:1] slot_v, slot_we, slot_mul, slot_div;
  logic [RW-1:0] slot_rd [MAXL:1];
  logic [NREG-1:0] pend;
  logic mem_wait;

  logic [LW-1:0] lat;
  logic known, late, sblk, dep, go;

  wire frozen = mem_wait & ~mem_ack;

  always_comb begin
    known = 1'b1;
    case (in_unit)
      U_ALU:   lat = LW'(LAT_ALU);
      U_IMUL:  lat = LW'(LAT_IMUL);
      U_FADD:  lat = LW'(LAT_FADD);
      U_FMUL:  lat = LW'(LAT_FMUL);
      U_FDIV:  lat = LW'(LAT_FDIV);
      U_LSU:   lat = LW'(LAT_LSU);
      default: begin lat = '0; known = 1'b0; end
    endcase
  end

  always_comb begin
    late = 1'b0;
    for (int k = 1; k <= MAXL; k++)
      if (slot_v[k] && k > int'(lat)) late = 1'b1;
  end

  assign sblk = (in_unit == U_FMUL && |slot_div) ||
                (in_unit == U_FDIV && (|slot_div || |slot_mul));
  assign dep  = pend[in_rs1] | pend[in_rs2] | (in_rd_en & pend[in_rd]);
  assign go   = in_valid & known & ~frozen & ~late & ~sblk & ~dep;

  assign stall     = in_valid & ~go;
  assign issue_stb = go ? (6'd1 << in_unit) : 6'd0;
  assign wb_valid  = slot_v[1] & ~frozen;
  assign wb_wen    = wb_valid & slot_we[1];
  assign wb_rd     = slot_rd[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v   <= '0;
      slot_we  <= '0;
      slot_mul <= '0;
      slot_div <= '0;
      for (int k = 1; k <= MAXL; k++) slot_rd[k] <= '0;
      pend     <= '0;
      mem_wait <= 1'b0;
    end else if (!frozen) begin
      for (int k = 1; k <= MAXL; k++) begin
        if (go && k == int'(lat)) begin
          slot_v[k]   <= 1'b1;
          slot_we[k]  <= in_rd_en;
          slot_mul[k] <= (in_unit == U_FMUL);
          slot_div[k] <= (in_unit == U_FDIV);
          slot_rd[k]  <= in_rd;
        end else if (k < MAXL) begin
          slot_v[k]   <= slot_v[k+1];
          slot_we[k]  <= slot_we[k+1];
          slot_mul[k] <= slot_mul[k+1];
          slot_div[k] <= slot_div[k+1];
          slot_rd[k]  <= slot_rd[k+1];
        end else begin
          slot_v[k]   <= 1'b0;
          slot_we[k]  <= 1'b0;
          slot_mul[k] <= 1'b0;
          slot_div[k] <= 1'b0;
          slot_rd[k]  <= '0;
        end
      end
      for (int r = 0; r < NREG; r++) begin
        if (go && in_rd_en && in_rd == RW'(r)) pend[r] <= 1'b1;
        else if (wb_wen && wb_rd == RW'(r))    pend[r] <= 1'b0;
      end
      mem_wait <= go && (in_unit == U_LSU);
    end
  end

endmodule

// File: rtl/inorder_issue_sched_chk.sv
module inorder_issue_sched_chk #(
  parameter int LAT_FMUL = 6,
  parameter int LAT_FDIV = 12,
  localparam int CW = $clog2(((LAT_FMUL > LAT_FDIV) ? LAT_FMUL : LAT_FDIV) + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [2:0] in_unit,
  input logic       mem_ack,
  input logic       mem_wait,
  input logic [5:0] issue_stb,
  input logic       stall,
  input logic       wb_valid
);

  logic [CW-1:0] fmul_left, fdiv_left;
  wire hold = mem_wait & ~mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmul_left <= '0;
      fdiv_left <= '0;
    end else if (!hold) begin
      if (issue_stb[3])        fmul_left <= CW'(LAT_FMUL);
      else if (fmul_left != 0) fmul_left <= fmul_left - 1'b1;
      if (issue_stb[4])        fdiv_left <= CW'(LAT_FDIV);
      else if (fdiv_left != 0) fdiv_left <= fdiv_left - 1'b1;
    end
  end

  // R1
  issue_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_stb));

  // R1
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (in_valid && issue_stb == 6'd0));

  // R2
  alu_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stb[0] |=> wb_valid);

  // R6
  fdiv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stb[4] |-> (fmul_left == 0 && fdiv_left == 0));

  // R6
  fmul_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stb[3] |-> (fdiv_left == 0));

  // R7
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wait && !mem_ack) |-> (issue_stb == 6'd0 && !wb_valid));

  // R9
  undef_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_unit > 3'd5) |-> stall);

endmodule

bind inorder_issue_sched inorder_issue_sched_chk #(
  .LAT_FMUL(LAT_FMUL), .LAT_FDIV(LAT_FDIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
  .mem_ack(mem_ack), .mem_wait(mem_wait), .issue_stb(issue_stb),
  .stall(stall), .wb_valid(wb_valid)
);

// File: tb/inorder_issue_sched_bench.sv
`timescale 1ns/1ps
module inorder_issue_sched_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_rd_en = 1'b0, mem_ack = 1'b1;
  logic [2:0] in_unit = 3'd0;
  logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [5:0] issue_stb;
  logic stall, wb_valid, wb_wen;
  logic [4:0] wb_rd;

  always #2.5 clk = ~clk;

  inorder_issue_sched u_inorder_issue_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_rd(in_rd), .in_rd_en(in_rd_en), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .mem_ack(mem_ack), .issue_stb(issue_stb), .stall(stall),
    .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd));

  int n_chk = 0, n_bad = 0, cyc = 0, ack_mode = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int latf(input logic [2:0] u);
    case (u)
      3'd0: return 1;  3'd1: return 3;  3'd2: return 4;
      3'd3: return 6;  3'd4: return 12; 3'd5: return 2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    case (ack_mode)
      0: mem_ack = ($urandom % 3) == 0;
      1: mem_ack = 1'b1;
      default: mem_ack = 1'b0;
    endcase

  // reference model: FIFO of outstanding completions, in issue order
  int q_wbt [64];
  int q_unit [64];
  logic [4:0] q_rd [64];
  bit q_we [64];
  int head = 0, tail = 0, acyc = 0;
  bit mw_m = 0, frz, e_wb, e_go, dep, sblk;
  int lat;
  string rq;

  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      frz  = mw_m && !mem_ack;
      e_wb = (head != tail) && q_wbt[head % 64] == acyc && !frz;
      chk(wb_valid == e_wb, frz ? "R7" : "R2", "wb_valid", wb_valid, e_wb);
      if (e_wb && wb_valid) begin
        chk(wb_wen == q_we[head % 64], "R2", "wb_wen", wb_wen, q_we[head % 64]);
        if (q_we[head % 64])
          chk(wb_rd == q_rd[head % 64], "R3", "wb_rd order", wb_rd, q_rd[head % 64]);
      end
      lat = latf(in_unit);
      dep = 0; sblk = 0;
      for (int i = head; i < tail; i++) begin
        if (q_we[i % 64] && (q_rd[i % 64] == in_rs1 || q_rd[i % 64] == in_rs2 ||
            (in_rd_en && q_rd[i % 64] == in_rd))) dep = 1;
        if (q_unit[i % 64] == 4 && (in_unit == 3 || in_unit == 4)) sblk = 1;
        if (q_unit[i % 64] == 3 && in_unit == 4) sblk = 1;
      end
      e_go = in_valid && lat > 0 && !frz && !dep && !sblk &&
             (head == tail || q_wbt[(tail - 1) % 64] < acyc + lat);
      rq = (in_valid && lat == 0) ? "R9" : frz ? "R7" : dep ? "R8" : sblk ? "R6" : "R1";
      chk(issue_stb == (e_go ? (6'd1 << in_unit) : 6'd0), rq, "issue_stb",
          issue_stb, e_go ? (1 << in_unit) : 0);
      chk(stall == (in_valid && !e_go), rq, "stall", stall, in_valid && !e_go);
      @(posedge clk);
      if (!frz) begin
        if (e_wb) head++;
        if (e_go) begin
          q_wbt[tail % 64] = acyc + lat; q_unit[tail % 64] = in_unit;
          q_rd[tail % 64] = in_rd; q_we[tail % 64] = in_rd_en; tail++;
        end
        mw_m = e_go && in_unit == 3'd5;
        acyc++;
      end
    end
  end

  task automatic send(input logic [2:0] u, input logic [4:0] rd, input bit we,
                      input logic [4:0] s1, input logic [4:0] s2, output int icyc);
    @(negedge clk);
    in_valid = 1'b1; in_unit = u; in_rd = rd; in_rd_en = we; in_rs1 = s1; in_rs2 = s2;
    #2;
    while (stall) begin @(negedge clk); #2; end
    icyc = cyc;
    @(posedge clk);
  endtask

  task automatic drain();
    ack_mode = 1;
    @(negedge clk); in_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic pair(input logic [2:0] u1, input logic [4:0] rd1,
                      input logic [2:0] u2, input logic [4:0] rd2, input bit we2,
                      input logic [4:0] s1, input int exp_gap, input string req);
    int a, b;
    drain();
    send(u1, rd1, 1'b1, 5'd30, 5'd30, a);
    send(u2, rd2, we2, s1, 5'd29, b);
    chk(b - a == exp_gap, req, "issue gap", b - a, exp_gap);
  endtask

  initial begin
    int a, b;
    void'($urandom(32'h1d5c_0a7e));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!stall && !wb_valid && issue_stb == 0, "R10", "idle after reset", stall, 0);
    send(3'd0, 5'd1, 1'b1, 5'd2, 5'd3, a);
    chk(a == cyc, "R10", "first ALU issues at once", a, cyc);

    pair(3'd3, 5'd1, 3'd1, 5'd2, 1'b1, 5'd3, 4, "R4");
    pair(3'd3, 5'd1, 3'd3, 5'd2, 1'b1, 5'd3, 1, "R5");
    pair(3'd2, 5'd1, 3'd2, 5'd2, 1'b1, 5'd3, 1, "R5");
    pair(3'd1, 5'd1, 3'd1, 5'd2, 1'b1, 5'd3, 1, "R5");
    pair(3'd1, 5'd7, 3'd0, 5'd2, 1'b1, 5'd3, 3, "R3");
    pair(3'd4, 5'd1, 3'd0, 5'd2, 1'b1, 5'd3, 12, "R3");
    pair(3'd1, 5'd7, 3'd0, 5'd2, 1'b1, 5'd7, 4, "R8");
    pair(3'd1, 5'd7, 3'd0, 5'd7, 1'b1, 5'd3, 4, "R8");
    pair(3'd1, 5'd7, 3'd0, 5'd7, 1'b0, 5'd3, 3, "R8");
    pair(3'd4, 5'd1, 3'd3, 5'd2, 1'b1, 5'd3, 13, "R6");
    pair(3'd3, 5'd1, 3'd4, 5'd2, 1'b1, 5'd3, 7, "R6");
    pair(3'd4, 5'd1, 3'd4, 5'd2, 1'b1, 5'd3, 13, "R6");

    drain();
    send(3'd5, 5'd4, 1'b1, 5'd30, 5'd30, a);
    ack_mode = 2;
    fork
      send(3'd0, 5'd5, 1'b1, 5'd3, 5'd3, b);
      begin repeat (5) @(posedge clk); ack_mode = 1; end
    join
    chk(b - a == 7, "R7", "issue after memory wait", b - a, 7);

    drain();
    @(negedge clk); in_valid = 1'b1; in_unit = 3'd6; in_rd_en = 1'b0;
    #2; chk(stall && issue_stb == 0, "R9", "code 6 held", stall, 1);
    @(negedge clk); in_unit = 3'd7;
    #2; chk(stall && issue_stb == 0, "R9", "code 7 held", stall, 1);

    ack_mode = 0;
    for (int n = 0; n < 3000; n++)
      send(3'($urandom % 6), 5'($urandom % 8), ($urandom % 4) != 0,
           5'($urandom % 8), 5'($urandom % 8), a);
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule